// File: doc/BRIEF.md
# Photodiode Conversion Sequencer

This block holds the digital counting and sequencing logic behind a charge-balancing integrating converter that serves two photodiode channels. The analog modulator hands it one pulse per balanced charge packet. The block counts those pulses over an integration window. At the end of the window it publishes a 16-bit result together with the length of the window in oscillator ticks. A one-cycle done pulse marks each new result.

There are two ways to set the window length. In internal timing it lasts a power-of-two number of oscillator ticks, with the exponent chosen by a resolution code. In external timing the host sets the window: it runs from one sync strobe to the next. A mode code picks what is converted. The choices are the first channel alone, the second channel alone, or both channels in turn with the second count taken away from the first. The block drives the channel select to the analog front end. It also drives a 2-bit gain range code, which is held steady for the whole conversion.

Top module: `photo_conv_seq`

## Requirements
- R1: With mode code 01, `chan_sel` stays 0 and the result equals the number of cycles with `mod_pulse` high. The count covers the cycles after the conversion starts, up to and including the cycle that ends it.
- R2: With mode code 10, `chan_sel` is 1 for the whole conversion, and the result is the pulse count of that single window.
- R3: With mode code 11, the block runs a window with `chan_sel`=0 and then a second window with `chan_sel`=1. Done fires only after the second window. The result is the first count minus the second count, and the timer gives the tick count of the second window.
- R4: In mode 11, when the second count is larger than the first, the result is 0.
- R5: In internal timing (`ext_timing`=0), a window ends on the 2^(4·(r+1))-th `osc_tick`, where r is the `res_sel` code 0..3. The timer reports the ticks counted in the window, saturating at 65535.
- R6: In external timing, a window runs from the cycle after one `sync_stb` through the cycle of the next strobe. The timer reports the `osc_tick` cycles inside that span.
- R7: After the block enters external timing, the first `sync_stb` only opens a window and raises no done.
- R8: The pulse count saturates at 65535 and does not wrap.
- R9: `result` and `timer` change only on the same clock edge that raises `done`. Otherwise they hold their last values.
- R10: `range_code` takes the value of `range_sel` when a conversion starts and does not change during that conversion.
- R11: `mode_sel` and `res_sel` are read only when a conversion starts. Changes made during a conversion do not affect it.
- R12: While reset is active, `done`, `result`, `timer`, `chan_sel` and `range_code` are all 0.
- R13: Mode code 00 behaves exactly as mode code 01.
- R14: Changing `ext_timing` abandons the conversion in progress without a done pulse. Conversion then restarts under the new timing mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle tick from the integration oscillator |
| mod_pulse | input | 1 | One-cycle pulse per balanced charge packet |
| mode_sel | input | 2 | Channel mode: 00/01 first channel, 10 second, 11 difference |
| res_sel | input | 2 | Internal window exponent code (4, 8, 12, 16 bits) |
| range_sel | input | 2 | Requested gain range |
| ext_timing | input | 1 | 1 = window set by host strobes |
| sync_stb | input | 1 | Host window strobe |
| chan_sel | output | 1 | Photodiode select to the front end (1 = second channel) |
| range_code | output | 2 | Gain range applied to the current conversion |
| result | output | 16 | Latest conversion result |
| timer | output | 16 | Tick count of the latest window |
| done | output | 1 | One-cycle pulse when a new result is published |

## Verification
The bench runs the difference mode with both signs of the difference. A block that does not clamp would publish a large wrapped value where 0 is expected. It runs a window of more than 65536 pulses in external timing. A counter that wraps there would report a small count instead of 65535. It checks that the first strobe after entering external timing raises no done; a block that gets this wrong would publish a meaningless count from the arming edge. It also changes the mode, the resolution and the range partway through a conversion, and flips the timing mode mid-window. A block that sampled its settings late would corrupt the conversion already under way, and one that missed the timing switch would emit a stale done.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_ARM   = 2'd1,
    ST_RUN   = 2'd2
  } pcs_state_t;

  localparam logic [1:0] MODE_CH2  = 2'b10;
  localparam logic [1:0] MODE_DIFF = 2'b11;
endpackage

// File: rtl/pcs_sat_cnt.sv
module pcs_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] MAXV = '1;

  always_comb begin
    nxt = cnt;
    if (inc && (cnt != MAXV)) nxt = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (inc)        cnt <= nxt;
  end

  // R8: a full counter stays full
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && inc && !clr) |=> (cnt == MAXV));
endmodule

// File: rtl/pcs_period_end.sv
module pcs_period_end #(
  parameter int W    = 16,
  parameter int STEP = 4
) (
  input  logic         ext_mode,
  input  logic         sync_stb,
  input  logic         osc_tick,
  input  logic [1:0]   res,
  input  logic [W-1:0] tick_cnt,
  output logic         end_evt
);
  logic [W-1:0] lim_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_lim
    localparam logic [W:0] SPAN = (W+1)'(1) << (STEP * (g + 1));
    assign lim_tab[g] = SPAN[W-1:0] - W'(1);
  end

  always_comb begin
    if (ext_mode) end_evt = sync_stb;
    else          end_evt = osc_tick && (tick_cnt == lim_tab[res]);
  end
endmodule

// File: rtl/pcs_combine.sv
module pcs_combine #(
  parameter int W = 16
) (
  input  logic         diff_mode,
  input  logic [W-1:0] first_cnt,
  input  logic [W-1:0] last_cnt,
  output logic [W-1:0] value
);
  always_comb begin
    if (!diff_mode)                 value = last_cnt;
    else if (first_cnt > last_cnt)  value = first_cnt - last_cnt;
    else                            value = '0;
  end
endmodule

// File: rtl/photo_conv_seq.sv
module photo_conv_seq
  import pcs_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RES_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             mod_pulse,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       res_sel,
  input  logic [1:0]       range_sel,
  input  logic             ext_timing,
  input  logic             sync_stb,
  output logic             chan_sel,
  output logic [1:0]       range_code,
  output logic [CNT_W-1:0] result,
  output logic [CNT_W-1:0] timer,
  output logic             done
);
  pcs_state_t       st_q, st_d;
  logic             ext_q, ext_d;
  logic [1:0]       mode_q, mode_d, res_q, res_d, rng_q, rng_d;
  logic             phase_q, phase_d, chan_q, chan_d, done_q, done_d;
  logic [CNT_W-1:0] hold_q, hold_d, result_q, result_d, timer_q, timer_d;

  logic             abort, in_run, end_evt, ph_end, diff_mode, last_phase;
  logic             finish, load, cnt_clr;
  logic [CNT_W-1:0] pulse_cnt, pulse_nxt, tick_cnt, tick_nxt, comb_y;

  assign in_run     = (st_q == ST_RUN);
  assign abort      = (st_q != ST_START) && (ext_timing != ext_q);
  assign diff_mode  = (mode_q == MODE_DIFF);
  assign last_phase = !diff_mode || phase_q;
  assign ph_end     = in_run && !abort && end_evt;
  assign finish     = ph_end && last_phase;
  assign load       = (st_q == ST_START) ||
                      ((st_q == ST_ARM) && !abort && sync_stb) || finish;
  assign cnt_clr    = !in_run || abort || ph_end;

  pcs_sat_cnt #(.W(CNT_W)) u_pulse_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(mod_pulse),
    .cnt(pulse_cnt), .nxt(pulse_nxt)
  );

  pcs_sat_cnt #(.W(CNT_W)) u_tick_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(osc_tick),
    .cnt(tick_cnt), .nxt(tick_nxt)
  );

  pcs_period_end #(.W(CNT_W), .STEP(RES_STEP)) u_period_end (
    .ext_mode(ext_q), .sync_stb(sync_stb), .osc_tick(osc_tick),
    .res(res_q), .tick_cnt(tick_cnt), .end_evt(end_evt)
  );

  pcs_combine #(.W(CNT_W)) u_combine (
    .diff_mode(diff_mode), .first_cnt(hold_q), .last_cnt(pulse_nxt),
    .value(comb_y)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    ext_d    = ext_q;
    mode_d   = mode_q;
    res_d    = res_q;
    rng_d    = rng_q;
    phase_d  = phase_q;
    chan_d   = chan_q;
    hold_d   = hold_q;
    result_d = result_q;
    timer_d  = timer_q;
    done_d   = 1'b0;
    case (st_q)
      ST_START: begin
        ext_d = ext_timing;
        st_d  = ext_timing ? ST_ARM : ST_RUN;
      end
      ST_ARM: begin
        if (abort)         st_d = ST_START;
        else if (sync_stb) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (abort) st_d = ST_START;
      end
      default: st_d = ST_START;
    endcase
    if (ph_end && !last_phase) begin
      hold_d  = pulse_nxt;
      phase_d = 1'b1;
      chan_d  = 1'b1;
    end
    if (finish) begin
      result_d = comb_y;
      timer_d  = tick_nxt;
      done_d   = 1'b1;
    end
    if (load) begin
      mode_d  = mode_sel;
      res_d   = res_sel;
      rng_d   = range_sel;
      phase_d = 1'b0;
      chan_d  = (mode_sel == MODE_CH2);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_START;
      ext_q    <= 1'b0;
      mode_q   <= '0;
      res_q    <= '0;
      rng_q    <= '0;
      phase_q  <= 1'b0;
      chan_q   <= 1'b0;
      hold_q   <= '0;
      result_q <= '0;
      timer_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ext_q   <= ext_d;
      phase_q <= phase_d;
      chan_q  <= chan_d;
      done_q  <= done_d;
      hold_q  <= hold_d;
      if (load) begin
        mode_q <= mode_d;
        res_q  <= res_d;
        rng_q  <= rng_d;
      end
      if (finish) begin
        result_q <= result_d;
        timer_q  <= timer_d;
      end
    end
  end

  assign chan_sel   = chan_q;
  assign range_code = rng_q;
  assign result     = result_q;
  assign timer      = timer_q;
  assign done       = done_q;

  // R9: published values move only with done
  assert_hold_between_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(result_q) && $stable(timer_q)));

  // R3: second channel only selected in its own mode/phase
  assert_chan_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chan_q |-> ((mode_q == MODE_CH2) || ((mode_q == MODE_DIFF) && phase_q)));

  // R10: range moves only at a conversion start
  assert_range_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rng_q) |-> $past(load));

  // R7: an armed block never publishes on the next edge
  assert_arm_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARM) |=> !done_q);
endmodule

// File: tb/photo_conv_seq_bench.sv
module photo_conv_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n, osc_tick, mod_pulse, ext_timing, sync_stb;
  logic [1:0]  mode_sel, res_sel, range_sel;
  logic        chan_sel, done;
  logic [1:0]  range_code;
  logic [15:0] result, timer;

  always #10 clk = ~clk;

  photo_conv_seq u_photo_conv_seq (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .mod_pulse(mod_pulse),
    .mode_sel(mode_sel), .res_sel(res_sel), .range_sel(range_sel),
    .ext_timing(ext_timing), .sync_stb(sync_stb), .chan_sel(chan_sel),
    .range_code(range_code), .result(result), .timer(timer), .done(done)
  );

  int checks = 0, failures = 0, cyc = 0;
  int k1 = 1, k2 = 1, osc_div = 1;
  string cur_req = "R12";
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stimulus patterns
  always @(negedge clk) begin
    int k;
    cyc++;
    osc_tick = (osc_div > 0) && (cyc % osc_div == 0);
    k = chan_sel ? k2 : k1;
    mod_pulse = (k > 0) && (cyc % k == 0);
  end

  // behavioural reference model
  int m_st, m_ext, m_mode, m_res, m_rng, m_phase, m_chan, m_hold, m_pc, m_tc;
  int m_out, m_tim, m_done;

  task m_load;
    m_mode = mode_sel; m_res = res_sel; m_rng = range_sel;
    m_phase = 0; m_chan = (mode_sel == 2); m_pc = 0; m_tc = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    int pn, tn, lim;
    bit ev, md;
    if (!rst_n) begin
      m_st = 0; m_ext = 0; m_mode = 0; m_res = 0; m_rng = 0; m_phase = 0;
      m_chan = 0; m_hold = 0; m_pc = 0; m_tc = 0; m_out = 0; m_tim = 0; m_done = 0;
    end else begin
      pn = (m_pc + mod_pulse > 65535) ? 65535 : m_pc + mod_pulse;
      tn = (m_tc + osc_tick > 65535) ? 65535 : m_tc + osc_tick;
      m_done = 0;
      if (m_st == 0) begin
        m_load(); m_ext = ext_timing; m_st = ext_timing ? 1 : 2;
      end else if (ext_timing != m_ext) begin
        m_st = 0; m_pc = 0; m_tc = 0;
      end else if (m_st == 1) begin
        if (sync_stb) begin m_load(); m_st = 2; end
      end else begin
        lim = (1 << (4 * (m_res + 1))) - 1;
        ev = m_ext ? sync_stb : (osc_tick && m_tc == lim);
        md = (m_mode == 3);
        if (ev) begin
          if (md && m_phase == 0) begin
            m_hold = pn; m_phase = 1; m_chan = 1; m_pc = 0; m_tc = 0;
          end else begin
            m_out = md ? ((m_hold > pn) ? m_hold - pn : 0) : pn;
            m_tim = tn; m_done = 1; m_load();
          end
        end else begin
          m_pc = pn; m_tc = tn;
        end
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done == m_done, cur_req, "done", done, m_done);
      chk(result == m_out, cur_req, "result", result, m_out);
      chk(timer == m_tim, cur_req, "timer", timer, m_tim);
      chk(chan_sel == m_chan, cur_req, "chan_sel", chan_sel, m_chan);
      chk(range_code == m_rng, cur_req, "range_code", range_code, m_rng);
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_done(output int r, output int t);
    int n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 100000);
    r = result; t = timer;
  endtask

  task automatic strobe;
    @(negedge clk); sync_stb = 1'b1;
    @(negedge clk); sync_stb = 1'b0;
  endtask

  initial begin
    int r, t, nd;
    rst_n = 0; mode_sel = 2'd1; res_sel = 2'd0; range_sel = 2'd0;
    ext_timing = 0; sync_stb = 0; osc_tick = 0; mod_pulse = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(done == 0 && result == 0 && timer == 0, "R12", "outputs in reset", result + timer + done, 0);
    chk(chan_sel == 0 && range_code == 0, "R12", "chan/range in reset", chan_sel + range_code, 0);
    rst_n = 1;

    cur_req = "R1";
    wait_done(r, t);
    chk(r == 16, "R1", "mode1 count", r, 16);
    chk(t == 16, "R5", "res0 ticks", t, 16);
    chk(chan_sel == 0, "R1", "chan mode1", chan_sel, 0);

    cur_req = "R2"; mode_sel = 2'd2; k2 = 2;
    wait_done(r, t); wait_done(r, t);
    chk(r == 8, "R2", "mode2 count", r, 8);
    chk(chan_sel == 1, "R2", "chan mode2", chan_sel, 1);

    cur_req = "R3"; mode_sel = 2'd3; k1 = 1; k2 = 4;
    wait_done(r, t); wait_done(r, t);
    chk(r == 12, "R3", "difference", r, 12);
    chk(t == 16, "R3", "second window ticks", t, 16);

    cur_req = "R4"; k1 = 4; k2 = 1;
    wait_done(r, t); wait_done(r, t);
    chk(r == 0, "R4", "negative clamp", r, 0);

    cur_req = "R13"; mode_sel = 2'd0; k1 = 2;
    wait_done(r, t); wait_done(r, t);
    chk(r == 8, "R13", "mode00 count", r, 8);
    chk(chan_sel == 0, "R13", "mode00 chan", chan_sel, 0);

    cur_req = "R5"; mode_sel = 2'd1; res_sel = 2'd1; k1 = 1; osc_div = 2;
    wait_done(r, t); wait_done(r, t);
    chk(t == 256, "R5", "res1 ticks", t, 256);
    chk(r == 512, "R5", "res1 pulses", r, 512);

    cur_req = "R11";
    repeat (20) @(negedge clk);
    mode_sel = 2'd2; res_sel = 2'd0; range_sel = 2'd3;
    repeat (5) @(negedge clk);
    chk(range_code == 0, "R10", "range held mid conversion", range_code, 0);
    wait_done(r, t);
    chk(r == 512 && t == 256, "R11", "old settings kept", r, 512);
    chk(range_code == 3, "R10", "range at new start", range_code, 3);
    chk(chan_sel == 1, "R11", "new mode applied", chan_sel, 1);

    osc_div = 1; mode_sel = 2'd1; k1 = 1;
    wait_done(r, t);
    cur_req = "R7"; ext_timing = 1;
    repeat (5) @(negedge clk);
    nd = 0;
    strobe();
    if (done) nd++;
    repeat (38) begin @(negedge clk); if (done) nd++; end
    chk(nd == 0, "R7", "done after arming strobe", nd, 0);
    cur_req = "R6";
    strobe();
    chk(done == 1, "R6", "done at second strobe", done, 1);
    chk(result == 40, "R6", "ext pulses", result, 40);
    chk(timer == 40, "R6", "ext ticks", timer, 40);

    cur_req = "R8";
    repeat (69998) @(negedge clk);
    strobe();
    chk(result == 65535, "R8", "saturated count", result, 65535);
    chk(timer == 65535, "R8", "saturated ticks", timer, 65535);

    cur_req = "R14";
    repeat (10) @(negedge clk);
    ext_timing = 0; nd = 0;
    repeat (3) begin @(negedge clk); if (done) nd++; end
    chk(nd == 0, "R14", "no done on timing switch", nd, 0);
    wait_done(r, t);
    chk(r == 16 && t == 16, "R14", "fresh internal window", r, 16);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule